// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with Compare-Clear and Overflow Modes

This block is a free-running up-counter of parameterised width (8 or 16 bits) whose count steps are gated by a clock prescaler. The prescaler divides the input clock by one of five fixed ratios, and a select code of zero (or any unused code) halts the counter. In compare-clear mode the counter returns to zero after it reaches a programmable compare value, so one period spans the compare value plus one timer ticks. In wrap mode the counter climbs to its all-ones value and then wraps to zero. A preload port writes a start value straight into the counter, which shortens the time to the next wrap.

Two single-cycle event pulses, one for a compare match and one for an overflow, mark the edge on which the counter returns to zero. They can drive interrupt logic directly. All control inputs are plain levels sampled on every rising clock edge. There is no data stream, so the block has no valid/ready handshake.

Top module: `prescaled_timer`

## Requirements
- R1: While `rst` is high on a rising edge, `count` becomes 0, both event outputs become 0 and the prescaler divider and the remembered select code are cleared.
- R2: `presc_sel` codes 1, 2, 3, 4, 5 make one timer tick every 1, 8, 64, 256, 1024 input clocks. Codes 0, 6 and 7 produce no ticks, so `count` holds its value.
- R3: Any change of `presc_sel` restarts the divider. After a preload of 0 that happens together with a select change to ratio r, `count` reads 1 after exactly r rising edges and then 2 after another r edges.
- R4: `count` changes only on a tick or a preload. On a tick that is neither a wrap nor a match it rises by exactly one.
- R5: With `mode` = 1 (compare-clear), the counter runs 0 up to `cmp_val` inclusive, then returns to 0 with `cmp_evt`. The match period is (`cmp_val` + 1) ticks. For example, ratio 64 with `cmp_val` = 249 gives 16000 input clocks.
- R6: In compare-clear mode with `cmp_val` = 0, every tick is a match. The counter stays at 0 and `cmp_evt` pulses once per tick.
- R7: In compare-clear mode, if the counter is above `cmp_val`, it counts up to all-ones and wraps to 0 with `ovf_evt` (not `cmp_evt`). It then reaches `cmp_val` and matches. When `cmp_val` equals all-ones, the match takes precedence and only `cmp_evt` fires.
- R8: With `mode` = 0 (wrap), the counter runs to all-ones, wraps to 0 and raises `ovf_evt`. A preload of 2^WIDTH − N gives an overflow after N ticks, and every later overflow comes after 2^WIDTH ticks.
- R9: When `preload_we` is high on an edge, `count` takes `preload_val` on that edge. This wins over a simultaneous tick, and no event is raised for that edge.
- R10: `cmp_evt` and `ovf_evt` rise on the same edge that sets `count` to 0. Neither is ever high together with the other. With a ratio above 1, each pulse is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_sel | input | 3 | Prescaler code: 1..5 = divide by 1, 8, 64, 256, 1024; other codes stop |
| mode | input | 1 | 1 = compare-clear, 0 = wrap at all-ones |
| cmp_val | input | WIDTH | Compare value for compare-clear mode |
| preload_val | input | WIDTH | Value written into the counter by a preload |
| preload_we | input | 1 | Preload strobe, one write per high cycle |
| count | output | WIDTH | Current counter value |
| cmp_evt | output | 1 | Compare-match pulse |
| ovf_evt | output | 1 | Overflow pulse |

## Verification
The bench times the first step after a select change against each ratio. A divider that is not restarted on a select change would take close to 1024 clocks to recover when it switches from a slow ratio to a fast one. The bench lowers the compare value below the running count: a design that compared with greater-or-equal would fire a match at once, instead of an overflow 106 clocks later. It writes a preload on the same edge as a tick at all-ones. A design that gave the increment priority would show 41, or a stray overflow, in place of 40. The bench also times the ratio-64 compare period and the ratio-256 full-range overflow period, where an off-by-one in the compare would show up as 15936 or 16064 clocks.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int SEL_W     = 3;
  localparam int N_RATIOS  = 5;
  localparam int MAX_SHIFT = 10;
  localparam int PS_DIV_W  = MAX_SHIFT;

  typedef enum logic {
    MODE_WRAP_MAX = 1'b0,
    MODE_CLR_CMP  = 1'b1
  } tmr_mode_e;

  // log2 of the division ratio for each valid select code
  function automatic int ratio_shift(input logic [SEL_W-1:0] code);
    case (code)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic code_runs(input logic [SEL_W-1:0] code);
    return (int'(code) >= 1) && (int'(code) <= N_RATIOS);
  endfunction

  // terminal value of the divider: ratio minus one
  function automatic logic [PS_DIV_W-1:0] div_limit(input logic [SEL_W-1:0] code);
    return PS_DIV_W'((1 << ratio_shift(code)) - 1);
  endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [SEL_W-1:0]    sel_q;
  logic [PS_DIV_W-1:0] div_q;
  logic [PS_DIV_W-1:0] lim;
  logic                run;
  logic                same_sel;

  always_comb begin
    lim      = div_limit(sel);
    run      = code_runs(sel);
    same_sel = (sel == sel_q);
    tick     = run && same_sel && (div_q == lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      div_q <= '0;
    end else begin
      sel_q <= sel;
      if (!same_sel || !run || tick) begin
        div_q <= '0;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr_mode,
  input  logic [WIDTH-1:0] cmp,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             ld_we,
  output logic [WIDTH-1:0] cnt,
  output logic             cmp_hit,
  output logic             ovf_hit
);

  logic [WIDTH-1:0] cnt_nxt;
  logic             hit_c;
  logic             hit_o;
  logic             at_max;
  logic             at_cmp;

  always_comb begin
    at_max  = (cnt == {WIDTH{1'b1}});
    at_cmp  = (cnt == cmp);
    cnt_nxt = cnt;
    hit_c   = 1'b0;
    hit_o   = 1'b0;
    if (ld_we) begin
      cnt_nxt = ld_val;
    end else if (tick) begin
      if (clr_mode && at_cmp) begin
        cnt_nxt = '0;
        hit_c   = 1'b1;
      end else if (at_max) begin
        cnt_nxt = '0;
        hit_o   = 1'b1;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cmp_hit <= 1'b0;
      ovf_hit <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      cmp_hit <= hit_c;
      ovf_hit <= hit_o;
    end
  end

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       presc_sel,
  input  logic             mode,
  input  logic [WIDTH-1:0] cmp_val,
  input  logic [WIDTH-1:0] preload_val,
  input  logic             preload_we,
  output logic [WIDTH-1:0] count,
  output logic             cmp_evt,
  output logic             ovf_evt
);

  logic tick;
  logic clr_mode;

  assign clr_mode = (mode == MODE_CLR_CMP);

  ptmr_prescaler i_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (presc_sel),
    .tick (tick)
  );

  ptmr_counter #(.WIDTH(WIDTH)) i_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .clr_mode (clr_mode),
    .cmp      (cmp_val),
    .ld_val   (preload_val),
    .ld_we    (preload_we),
    .cnt      (count),
    .cmp_hit  (cmp_evt),
    .ovf_hit  (ovf_evt)
  );

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       presc_sel,
  input logic             mode,
  input logic [WIDTH-1:0] cmp_val,
  input logic [WIDTH-1:0] preload_val,
  input logic             preload_we,
  input logic [WIDTH-1:0] count,
  input logic             cmp_evt,
  input logic             ovf_evt,
  input logic             tick
);

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (count == '0) && !cmp_evt && !ovf_evt);

  // R2
  stop_code_chk: assert property (@(posedge clk) disable iff (rst)
    ((presc_sel == 3'd0) || (presc_sel > 3'd5)) |-> !tick);

  // R3
  sel_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (presc_sel != $past(presc_sel)) |-> !tick);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !preload_we) |=> $stable(count));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !preload_we && (count != {WIDTH{1'b1}}) && !(mode && (count == cmp_val)))
    |=> (count == $past(count) + 1'b1));

  // R5
  match_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !preload_we && mode && (count == cmp_val)) |=> cmp_evt && (count == '0));

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !preload_we && !mode && (count == {WIDTH{1'b1}})) |=> ovf_evt && (count == '0));

  // R9
  preload_chk: assert property (@(posedge clk) disable iff (rst)
    preload_we |=> (count == $past(preload_val)) && !cmp_evt && !ovf_evt);

  // R10
  cmp_zero_chk: assert property (@(posedge clk) disable iff (rst) cmp_evt |-> (count == '0));

  // R10
  ovf_zero_chk: assert property (@(posedge clk) disable iff (rst) ovf_evt |-> (count == '0));

  // R10
  evt_excl_chk: assert property (@(posedge clk) disable iff (rst) !(cmp_evt && ovf_evt));

endmodule

bind prescaled_timer ptmr_checker #(.WIDTH(WIDTH)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .presc_sel   (presc_sel),
  .mode        (mode),
  .cmp_val     (cmp_val),
  .preload_val (preload_val),
  .preload_we  (preload_we),
  .count       (count),
  .cmp_evt     (cmp_evt),
  .ovf_evt     (ovf_evt),
  .tick        (tick)
);

// File: tb/test_prescaled_timer.sv
`timescale 1ns/1ps
module test_prescaled_timer;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   presc_sel = 3'd0;
  logic         mode = 1'b0;
  logic [W-1:0] cmp_val = '0;
  logic [W-1:0] preload_val = '0;
  logic         preload_we = 1'b0;
  logic [W-1:0] count;
  logic         cmp_evt;
  logic         ovf_evt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prescaled_timer #(.WIDTH(W)) i_prescaled_timer (
    .clk(clk), .rst(rst), .presc_sel(presc_sel), .mode(mode), .cmp_val(cmp_val),
    .preload_val(preload_val), .preload_we(preload_we), .count(count),
    .cmp_evt(cmp_evt), .ovf_evt(ovf_evt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input int v);
    preload_val = W'(v);
    preload_we  = 1'b1;
    step();
    preload_we  = 1'b0;
  endtask

  task automatic wait_cnt(input int v, input int limit, output int k);
    k = 0;
    do begin
      step();
      k++;
    end while ((int'(count) != v) && (k < limit));
  endtask

  task automatic wait_any(input int limit, output int k, output bit c, output bit o);
    k = 0;
    do begin
      step();
      k++;
    end while (!cmp_evt && !ovf_evt && (k < limit));
    c = cmp_evt;
    o = ovf_evt;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    chk("R1 count in reset", int'(count), 0);
    chk("R1 cmp_evt in reset", int'(cmp_evt), 0);
    chk("R1 ovf_evt in reset", int'(ovf_evt), 0);
    rst = 1'b0;
    step();
    chk("R1 count held after reset with stop code", int'(count), 0);
  endtask

  task automatic t_ratios();
    int k;
    mode = 1'b0;
    for (int c = 1; c <= 5; c++) begin
      int r;
      r = (c == 1) ? 1 : (c == 2) ? 8 : (c == 3) ? 64 : (c == 4) ? 256 : 1024;
      presc_sel = 3'(c);
      load(0);
      wait_cnt(1, 4000, k);
      chk($sformatf("R3 first step after select change, code %0d", c), k, r);
      wait_cnt(2, 4000, k);
      chk($sformatf("R2 tick spacing, code %0d", c), k, r);
    end
  endtask

  task automatic t_stop();
    int codes[3] = '{0, 6, 7};
    mode = 1'b0;
    foreach (codes[i]) begin
      presc_sel = 3'(codes[i]);
      load(5);
      repeat (2000) step();
      chk($sformatf("R2 stop code %0d holds count", codes[i]), int'(count), 5);
    end
  endtask

  task automatic t_restart();
    int k;
    mode = 1'b0;
    presc_sel = 3'd3;
    step();
    repeat (20) step();
    presc_sel = 3'd2;
    load(0);
    wait_cnt(1, 4000, k);
    chk("R3 divider restarts on mid-run select change", k, 8);
  endtask

  task automatic t_ctc();
    int k;
    bit c, o;
    mode = 1'b1;
    cmp_val = 8'd249;
    presc_sel = 3'd3;
    load(0);
    wait_any(40000, k, c, o);
    chk("R5 first compare after 250 ticks of 64", k, 16000);
    chk("R5 compare event raised", int'(c), 1);
    chk("R10 count zero with compare event", int'(count), 0);
    step();
    chk("R10 compare pulse one clock wide", int'(cmp_evt), 0);
    wait_any(40000, k, c, o);
    chk("R5 compare period 16000 clocks", k + 1, 16000);
    chk("R10 no overflow in compare run", int'(o), 0);
  endtask

  task automatic t_cmp_zero();
    int k;
    bit c, o;
    mode = 1'b1;
    cmp_val = '0;
    presc_sel = 3'd2;
    load(0);
    wait_any(100, k, c, o);
    chk("R6 match on first tick with compare 0", k, 8);
    chk("R6 count stays 0", int'(count), 0);
    wait_any(100, k, c, o);
    chk("R6 match on every tick", k, 8);
    chk("R6 event is compare", int'(c), 1);
  endtask

  task automatic t_cmp_lowered();
    int k;
    bit c, o;
    mode = 1'b1;
    presc_sel = 3'd1;
    step();
    cmp_val = 8'd100;
    load(150);
    wait_any(1000, k, c, o);
    chk("R7 count above compare wraps through max", k, 106);
    chk("R7 wrap raises overflow", int'(o), 1);
    chk("R7 wrap raises no compare", int'(c), 0);
    wait_any(1000, k, c, o);
    chk("R7 match follows wrap", k, 101);
    chk("R7 match raises compare", int'(c), 1);
    cmp_val = 8'd255;
    load(250);
    wait_any(100, k, c, o);
    chk("R7 compare at all-ones gives compare event", int'(c), 1);
    chk("R7 compare at all-ones gives no overflow", int'(o), 0);
  endtask

  task automatic t_normal();
    int k;
    bit c, o;
    mode = 1'b0;
    presc_sel = 3'd1;
    step();
    load(246);
    wait_any(1000, k, c, o);
    chk("R8 preload 256-10 overflows after 10 ticks", k, 10);
    chk("R8 overflow event raised", int'(o), 1);
    wait_any(1000, k, c, o);
    chk("R8 full range period 256", k, 256);
    presc_sel = 3'd4;
    load(255);
    wait_any(1000, k, c, o);
    chk("R8 overflow from 255 at ratio 256", k, 256);
    step();
    chk("R10 overflow pulse one clock wide", int'(ovf_evt), 0);
    wait_any(70000, k, c, o);
    chk("R8 full range period 65536 at ratio 256", k + 1, 65536);
    chk("R8 event is overflow", int'(o), 1);
  endtask

  task automatic t_preload_prio();
    mode = 1'b0;
    presc_sel = 3'd1;
    step();
    load(255);
    load(40);
    chk("R9 preload wins over tick at all-ones", int'(count), 40);
    chk("R9 no overflow on preload edge", int'(ovf_evt), 0);
    step();
    chk("R4 next tick increments by one", int'(count), 41);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ratios();
    t_stop();
    t_restart();
    t_ctc();
    t_cmp_zero();
    t_cmp_lowered();
    t_normal();
    t_preload_prio();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
    end
  end

endmodule